// File: doc/BRIEF.md
# Loop-Bound Predicate Mask Generator

This block produces the active-lane predicate for a vector loop-control step of the kind "keep lanes active while the running index is below (or at most) the bound". It receives a start value and a bound as two scalar operands. Select inputs give the operand width (32 or 64 bits), signed or unsigned comparison, an exclusive or inclusive bound, and the element size. From these the block works out how many leading lanes are active. It returns a predicate image with one bit per vector byte and a set of condition flags.

The lane count is the distance from the start value to the bound. One is added for an inclusive bound. The count is forced to zero when the start already fails the comparison. It is capped at the number of lanes that fit in the vector. An inclusive bound equal to the largest representable integer makes every lane active, which matches an increment-and-compare loop that can never fail its test. The capped count is then scaled by the element size and spread into the predicate, one marker bit per active element. The vector length is fixed when the block is built.

Top module: `lanepred_gen`

## Requirements
- R1: With `wide_i`=0 only the low 32 bits of each operand are used. They are zero-extended when `uns_i`=1 and sign-extended when `uns_i`=0, before any subtraction or comparison.
- R2: The active-lane count is `opb_i - opa_i` when `incl_i`=0 and `opb_i - opa_i + 1` when `incl_i`=1.
- R3: With `incl_i`=1, if `opb_i` equals the largest integer for the selected width and signedness, every lane is active, whatever `opa_i` is.
- R4: The count is capped, as an unsigned value, at the lane count. The lane count is VLEN/8 shifted right by `esize_i`.
- R5: The comparison of `opa_i` against `opb_i` is unsigned when `uns_i`=1 and signed when `uns_i`=0. It is "<" when `incl_i`=0 and "<=" when `incl_i`=1. When it is false the count is zero and the predicate is all clear.
- R6: `esize_i` values 0, 1, 2 and 3 select element sizes of 1, 2, 4 and 8 bytes. Predicate bit i is 1 exactly when i < count·2^esize and i is a multiple of 2^esize. All other bits are 0.
- R7: `flag_n_o` is 1 when the first element is active. `flag_z_o` is 1 when no element is active. `flag_c_o` is 1 when the last element is not active. `flag_v_o` is always 0.
- R8: The inputs are sampled on the clock edge at which `start_i` is 1. At that same edge `pred_o` and the flags take the result and `done_o` goes to 1 for exactly one cycle. Without `start_i` the outputs keep their values, even if the inputs change.
- R9: Reset (`rst_n`=0) gives `done_o`=0, `pred_o`=0, `flag_n_o`=0, `flag_z_o`=1, `flag_c_o`=1 and `flag_v_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample the operands and produce a new result |
| opa_i | input | 64 | Start value of the loop index |
| opb_i | input | 64 | Loop bound |
| wide_i | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| uns_i | input | 1 | 1: unsigned compare, 0: signed compare |
| incl_i | input | 1 | 1: inclusive bound (<=), 0: exclusive bound (<) |
| esize_i | input | 2 | Element size code (0..3 = 1, 2, 4, 8 bytes) |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| pred_o | output | VLEN/8 | Predicate image, one bit per vector byte |
| flag_n_o | output | 1 | First element active |
| flag_z_o | output | 1 | No element active |
| flag_c_o | output | 1 | Last element not active |
| flag_v_o | output | 1 | Always 0 |

## Verification
The predicate, all four flags and the done pulse go through a single register stage. They all change at the rising edge that samples `start_i`=1. The bench drives operands and the strobe on the falling edge and drops the strobe on the next falling edge. It then reads every result at that falling edge, half a cycle after the capturing edge. One cycle later it samples again to confirm that `done_o` has fallen and that the predicate has held while the operands were changed without a strobe.

// File: rtl/lanepred_pkg.sv
package lanepred_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_DBL  = 2'd3
   } esz_e;

   localparam int OPW = 64;

   // largest integer of the chosen width/signedness, in its 64-bit extended form
   function automatic logic [OPW-1:0] int_ceiling(input logic wide, input logic uns);
      logic [OPW-1:0] r;
      case ({wide, uns})
         2'b11:   r = {OPW{1'b1}};
         2'b10:   r = {1'b0, {(OPW-1){1'b1}}};
         2'b01:   r = {{(OPW/2){1'b0}}, {(OPW/2){1'b1}}};
         default: r = {{(OPW/2+1){1'b0}}, {(OPW/2-1){1'b1}}};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lanepred_norm.sv
module lanepred_norm #(
   parameter int W = 64
) (
   input  logic [W-1:0] op_i,
   input  logic         wide_i,
   input  logic         uns_i,
   output logic [W-1:0] op_o
);
   localparam int HALF = W / 2;

   always_comb begin
      if (wide_i)
         op_o = op_i;
      else if (uns_i)
         op_o = {{HALF{1'b0}}, op_i[HALF-1:0]};
      else
         op_o = {{HALF{op_i[HALF-1]}}, op_i[HALF-1:0]};
   end
endmodule

// File: rtl/lanepred_count.sv
module lanepred_count
   import lanepred_pkg::*;
#(
   parameter int VBYTES = 32,
   parameter int CNT_W  = 6
) (
   input  logic [OPW-1:0]   a_i,
   input  logic [OPW-1:0]   b_i,
   input  logic             wide_i,
   input  logic             uns_i,
   input  logic             incl_i,
   input  esz_e             esz_i,
   output logic [CNT_W-1:0] lanes_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] VB_C = CNT_W'(VBYTES);

   logic [OPW-1:0]   span;
   logic [OPW-1:0]   raw;
   logic             at_ceiling;
   logic             pass;
   logic [CNT_W-1:0] capped;

   assign lanes_o    = VB_C >> esz_i;
   assign span       = (b_i - a_i) + (incl_i ? OPW'(1) : OPW'(0));
   assign at_ceiling = incl_i && (b_i == int_ceiling(wide_i, uns_i));
   assign raw        = at_ceiling ? OPW'(lanes_o) : span;
   assign capped     = (raw < OPW'(lanes_o)) ? raw[CNT_W-1:0] : lanes_o;

   always_comb begin
      if (uns_i)
         pass = incl_i ? (a_i <= b_i) : (a_i < b_i);
      else
         pass = incl_i ? ($signed(a_i) <= $signed(b_i)) : ($signed(a_i) < $signed(b_i));
   end

   assign cnt_o = pass ? capped : '0;
endmodule

// File: rtl/lanepred_mask.sv
module lanepred_mask
   import lanepred_pkg::*;
#(
   parameter int PBITS = 32,
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  esz_e             esz_i,
   output logic [PBITS-1:0] pred_o
);
   logic [CNT_W-1:0] nbits;

   assign nbits = cnt_i << esz_i;

   for (genvar i = 0; i < PBITS; i++) begin : g_bit
      localparam logic ALN2 = (i % 2) == 0;
      localparam logic ALN4 = (i % 4) == 0;
      localparam logic ALN8 = (i % 8) == 0;
      logic aligned;
      always_comb begin
         case (esz_i)
            ESZ_BYTE: aligned = 1'b1;
            ESZ_HALF: aligned = ALN2;
            ESZ_WORD: aligned = ALN4;
            default:  aligned = ALN8;
         endcase
      end
      assign pred_o[i] = aligned && (CNT_W'(i) < nbits);
   end
endmodule

// File: rtl/lanepred_gen.sv
module lanepred_gen
   import lanepred_pkg::*;
#(
   parameter  int VLEN  = 256,
   localparam int PBITS = VLEN / 8,
   localparam int CNT_W = $clog2(PBITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [63:0]      opa_i,
   input  logic [63:0]      opb_i,
   input  logic             wide_i,
   input  logic             uns_i,
   input  logic             incl_i,
   input  logic [1:0]       esize_i,
   output logic             done_o,
   output logic [PBITS-1:0] pred_o,
   output logic             flag_n_o,
   output logic             flag_z_o,
   output logic             flag_c_o,
   output logic             flag_v_o
);
   if ((VLEN % 128) != 0 || VLEN < 128 || VLEN > 2048) begin : g_bad_vlen
      $error("lanepred_gen: VLEN must be a multiple of 128 in 128..2048");
   end

   logic [1:0][OPW-1:0] op_raw;
   logic [1:0][OPW-1:0] op_ext;
   logic [CNT_W-1:0]    lanes;
   logic [CNT_W-1:0]    cnt;
   logic [PBITS-1:0]    pred_nxt;
   esz_e                esz;

   assign op_raw = {opb_i, opa_i};
   assign esz    = esz_e'(esize_i);

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      lanepred_norm #(.W(OPW)) u_norm (
         .op_i   (op_raw[k]),
         .wide_i (wide_i),
         .uns_i  (uns_i),
         .op_o   (op_ext[k])
      );
   end

   lanepred_count #(.VBYTES(PBITS), .CNT_W(CNT_W)) u_count (
      .a_i     (op_ext[0]),
      .b_i     (op_ext[1]),
      .wide_i  (wide_i),
      .uns_i   (uns_i),
      .incl_i  (incl_i),
      .esz_i   (esz),
      .lanes_o (lanes),
      .cnt_o   (cnt)
   );

   lanepred_mask #(.PBITS(PBITS), .CNT_W(CNT_W)) u_mask (
      .cnt_i  (cnt),
      .esz_i  (esz),
      .pred_o (pred_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         pred_o   <= '0;
         flag_n_o <= 1'b0;
         flag_z_o <= 1'b1;
         flag_c_o <= 1'b1;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            pred_o   <= pred_nxt;
            flag_n_o <= pred_nxt[0];
            flag_z_o <= (cnt == '0);
            flag_c_o <= (cnt != lanes);
         end
      end
   end

   assign flag_v_o = 1'b0;
endmodule

// File: rtl/lanepred_chk.sv
module lanepred_chk #(
   parameter int PBITS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             done_o,
   input logic [PBITS-1:0] pred_o,
   input logic             flag_n_o,
   input logic             flag_z_o,
   input logic             flag_c_o,
   input logic             flag_v_o
);
   // R8
   done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   // R8
   done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i));
   // R8
   pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(pred_o));
   // R7
   zero_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z_o |-> (pred_o == '0));
   // R7
   full_means_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_c_o |-> flag_n_o);
   // R6
   active_has_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_z_o |-> pred_o[0]);
   // R7
   v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_v_o);
endmodule

bind lanepred_gen lanepred_chk #(.PBITS(PBITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .done_o   (done_o),
   .pred_o   (pred_o),
   .flag_n_o (flag_n_o),
   .flag_z_o (flag_z_o),
   .flag_c_o (flag_c_o),
   .flag_v_o (flag_v_o)
);

// File: tb/lanepred_gen_tb.sv
`timescale 1ns/1ps
module lanepred_gen_tb;
   localparam int VLEN = 256;
   localparam int VB   = VLEN / 8;
   localparam int NPAIR = 12;

   // {opa, opb}
   localparam logic [127:0] PAIRS [NPAIR] = '{
      {64'h0, 64'h0},
      {64'h0, 64'h5},
      {64'h3, 64'hA},
      {64'hA, 64'h3},
      {64'h0, 64'h64},
      {64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF},
      {64'h7FFF_FFFF_FFFF_FFF0, 64'h7FFF_FFFF_FFFF_FFFF},
      {64'h0000_0000_FFFF_FFFE, 64'h0000_0000_FFFF_FFFF},
      {64'h0000_0000_7FFF_FFF8, 64'h0000_0000_7FFF_FFFF},
      {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0004},
      {64'hFFFF_FFFF_FFFF_FFFE, 64'h2},
      {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0003}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [63:0]   opa_i = '0, opb_i = '0;
   logic          wide_i = 1'b0, uns_i = 1'b0, incl_i = 1'b0;
   logic [1:0]    esize_i = '0;
   logic          done_o;
   logic [VB-1:0] pred_o;
   logic          flag_n_o, flag_z_o, flag_c_o, flag_v_o;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   lanepred_gen #(.VLEN(VLEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .opa_i(opa_i), .opb_i(opb_i), .wide_i(wide_i), .uns_i(uns_i),
      .incl_i(incl_i), .esize_i(esize_i), .done_o(done_o), .pred_o(pred_o),
      .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
      .flag_v_o(flag_v_o)
   );

   function automatic logic [63:0] ext(input logic [63:0] v, input logic w, input logic u);
      if (w) return v;
      if (u) return {32'h0, v[31:0]};
      return {{32{v[31]}}, v[31:0]};
   endfunction

   // behavioural increment-and-compare loop
   function automatic int ref_count(input logic [63:0] a, input logic [63:0] b,
                                    input logic w, input logic u, input logic inc,
                                    input logic [1:0] es);
      logic [63:0] x, bb;
      logic alive, ok;
      int n;
      x = ext(a, w, u);
      bb = ext(b, w, u);
      alive = 1'b1;
      n = 0;
      for (int e = 0; e < (VB >> es); e++) begin
         if (u) ok = inc ? (x <= bb) : (x < bb);
         else   ok = inc ? ($signed(x) <= $signed(bb)) : ($signed(x) < $signed(bb));
         alive = alive && ok;
         if (alive) n++;
         x = ext(x + 64'd1, w, u);
      end
      return n;
   endfunction

   function automatic logic [VB-1:0] ref_pred(input int n, input logic [1:0] es);
      logic [VB-1:0] p;
      p = '0;
      for (int i = 0; i < VB; i++)
         if (i < (n << es) && (i % (1 << es)) == 0) p[i] = 1'b1;
      return p;
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic w,
                        input logic u, input logic inc, input logic [1:0] es);
      @(negedge clk);
      opa_i = a; opb_i = b; wide_i = w; uns_i = u; incl_i = inc; esize_i = es;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic check_full(input string req, input logic [VB-1:0] ep, input int n,
                             input logic [1:0] es);
      check(pred_o == ep, req, 64'(pred_o), 64'(ep));
      check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} ==
            {n > 0, n == 0, n != (VB >> es), 1'b0},
            {req, " R7 flags"}, 64'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}),
            64'({n > 0, n == 0, n != (VB >> es), 1'b0}));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk);
      // R9 reset state
      check({done_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 5'b00110, "R9 flags",
            64'({done_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o}), 64'(5'b00110));
      check(pred_o == '0, "R9 pred", 64'(pred_o), 64'h0);
      rst_n = 1'b1;

      // table sweep over every mode combination
      for (int p = 0; p < NPAIR; p++)
         for (int m = 0; m < 32; m++) begin
            logic [1:0] es;
            es = m[1:0];
            issue(PAIRS[p][127:64], PAIRS[p][63:0], m[4], m[3], m[2], es);
            n = ref_count(PAIRS[p][127:64], PAIRS[p][63:0], m[4], m[3], m[2], es);
            check(done_o, "R8 done", 64'(done_o), 64'h1);
            check_full("R2 R6 sweep", ref_pred(n, es), n, es);
         end

      // R1 zero-extension drops upper bits
      issue(64'hFFFF_FFFF_0000_0002, 64'h5, 1'b0, 1'b1, 1'b0, 2'd0);
      check(pred_o == 32'h7, "R1 zext", 64'(pred_o), 64'h7);
      // R1 sign-extension: -2 < 1
      issue(64'h0000_0000_FFFF_FFFE, 64'h1, 1'b0, 1'b0, 1'b0, 2'd0);
      check(pred_o == 32'h7, "R1 sext", 64'(pred_o), 64'h7);
      // R2 inclusive adds one
      issue(64'h2, 64'h4, 1'b1, 1'b1, 1'b1, 2'd0);
      check(pred_o == 32'h7, "R2 incl", 64'(pred_o), 64'h7);
      issue(64'h2, 64'h4, 1'b1, 1'b1, 1'b0, 2'd0);
      check(pred_o == 32'h3, "R2 excl", 64'(pred_o), 64'h3);
      // R3 inclusive at ceiling
      issue(64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'd2);
      check(pred_o == 32'h1111_1111, "R3 u64", 64'(pred_o), 64'h1111_1111);
      issue(64'h0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 1'b1, 2'd3);
      check(pred_o == 32'h0101_0101, "R3 s32", 64'(pred_o), 64'h0101_0101);
      // R4 clamp at lane count
      issue(64'h0, 64'd100, 1'b1, 1'b1, 1'b0, 2'd1);
      check(pred_o == 32'h5555_5555, "R4 clamp", 64'(pred_o), 64'h5555_5555);
      check(!flag_c_o, "R4 last lane active", 64'(flag_c_o), 64'h0);
      // R5 signed false condition vs unsigned true
      issue(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0);
      check(pred_o == '0 && flag_z_o, "R5 signed", 64'(pred_o), 64'h0);
      issue(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'd0);
      check(pred_o == 32'hFFFF_FFFF, "R5 unsigned", 64'(pred_o), 64'hFFFF_FFFF);
      // R7 partial predicate flags
      issue(64'h0, 64'h3, 1'b1, 1'b1, 1'b0, 2'd0);
      check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} == 4'b1010, "R7 partial",
            64'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), 64'hA);
      // R8 pulse drops and outputs hold without start
      opa_i = 64'h0; opb_i = 64'h1F; esize_i = 2'd0;
      @(negedge clk);
      check(!done_o, "R8 pulse", 64'(done_o), 64'h0);
      check(pred_o == 32'h7, "R8 hold", 64'(pred_o), 64'h7);
      check(flag_c_o && flag_n_o, "R8 flags hold", 64'({flag_n_o, flag_c_o}), 64'h3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule